// File: doc/BRIEF.md
# Dual-Core GPIO Output-Enable Register

This block holds the direction control for thirty general-purpose pins and drives it to the pad logic. A one in a bit makes the matching pin an output. A zero leaves the pin as an input. Two processor cores share the register. Each core has its own write strobe, a two-bit operation selector, 32-bit write data and a 32-bit readback. Every core can replace the whole value, or it can change selected bits atomically: OR them in, clear them, or invert them.

When both cores write in the same clock cycle, the updates are chained. Core 0's operation is applied to the current contents first. Core 1's operation is then applied to that intermediate value, and the result is stored. The update is computed combinationally and captured on the clock edge. A write therefore shows on both readbacks and on the pin vector in the next cycle. Data bits 31 and 30 have no pin and are discarded.

Top module: `gpio_oe_dual_core`

## Requirements
- R1: While rst_ni is low, all 30 stored bits are 0, so every pin is an input. The clear happens asynchronously and holds until reset is released.
- R2: Operation code 2'b00 (plain) stores wdata[29:0] unchanged. The new value appears on oe_o and on both read ports one clock after the strobe.
- R3: Write data bits 31 and 30 never affect the stored value under any operation, and rdata bits 31 and 30 always read 0.
- R4: Operation code 2'b01 (set) ORs wdata[29:0] into the current value.
- R5: Operation code 2'b10 (clear) forces to 0 every bit where wdata[29:0] is 1 and leaves the other bits alone.
- R6: Operation code 2'b11 (toggle) inverts every bit where wdata[29:0] is 1 and leaves the other bits alone.
- R7: When only one core strobes, its operation alone is applied to the current value, whichever core it is.
- R8: When both cores strobe in the same cycle, the stored result is core 1's operation applied to the result of core 0's operation on the current value.
- R9: When neither core strobes, the stored value and oe_o do not change.
- R10: Both read ports return {2'b00, oe_o}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| c0_we_i | input | 1 | Core 0 write strobe, one cycle per write |
| c0_op_i | input | 2 | Core 0 operation: 00 plain, 01 set, 10 clear, 11 toggle |
| c0_wdata_i | input | 32 | Core 0 write data |
| c0_rdata_o | output | 32 | Core 0 readback |
| c1_we_i | input | 1 | Core 1 write strobe, one cycle per write |
| c1_op_i | input | 2 | Core 1 operation: 00 plain, 01 set, 10 clear, 11 toggle |
| c1_wdata_i | input | 32 | Core 1 write data |
| c1_rdata_o | output | 32 | Core 1 readback |
| oe_o | output | 30 | Output enable per pin, 1 = output |

## Verification
The assertions check some rules on every cycle:
- each stage of the update chain obeys its operation (plain, set, clear, toggle or pass-through);
- the value holds when idle;
- the upper read bits stay zero;
- both readbacks agree with the pin vector;
- the value is zero coming out of reset.

Some properties depend on what happens across clock edges, and only the bench scenarios can show them:
- the ordering of same-cycle writes, where core 0 applies before core 1, checked with pairs whose result changes if the order is swapped;
- the one-cycle latency from strobe to output;
- reset striking in the middle of a run.

// File: rtl/gpio_oe_pkg.sv
package gpio_oe_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } oe_op_e;
endpackage

// File: rtl/gpio_oe_alias_unit.sv
module gpio_oe_alias_unit
  import gpio_oe_pkg::*;
#(
  parameter int unsigned NUM_PINS = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  oe_op_e              op_i,
  input  logic [NUM_PINS-1:0] data_i,
  input  logic [NUM_PINS-1:0] cur_i,
  output logic [NUM_PINS-1:0] nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    if (we_i) begin
      unique case (op_i)
        OP_PLAIN:  nxt_o = data_i;
        OP_SET:    nxt_o = cur_i | data_i;
        OP_CLEAR:  nxt_o = cur_i & ~data_i;
        OP_TOGGLE: nxt_o = cur_i ^ data_i;
        default:   nxt_o = cur_i;
      endcase
    end
  end

  AST_PLAIN_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_PLAIN) |-> (nxt_o == data_i)); // R2
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_SET) |-> (((nxt_o & cur_i) == cur_i) && ((nxt_o & data_i) == data_i))); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_CLEAR) |-> (((nxt_o & data_i) == '0) && ((nxt_o & ~data_i) == (cur_i & ~data_i)))); // R5
  AST_TOGGLE_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && op_i == OP_TOGGLE) |-> ((nxt_o ^ cur_i) == data_i)); // R6
  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> (nxt_o == cur_i)); // R7

endmodule

// File: rtl/gpio_oe_merge_chain.sv
module gpio_oe_merge_chain
  import gpio_oe_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 30,
  parameter int unsigned NUM_CORES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CORES-1:0] we_i,
  input  oe_op_e              op_i   [NUM_CORES],
  input  logic [NUM_PINS-1:0] data_i [NUM_CORES],
  input  logic [NUM_PINS-1:0] cur_i,
  output logic [NUM_PINS-1:0] nxt_o,
  output logic                any_we_o
);

  // stage[k] is the value after cores 0..k-1 have applied, lowest index first
  logic [NUM_PINS-1:0] stage [NUM_CORES+1];

  assign stage[0] = cur_i;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    gpio_oe_alias_unit #(
      .NUM_PINS(NUM_PINS)
    ) u_alias (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_i[g]),
      .op_i   (op_i[g]),
      .data_i (data_i[g]),
      .cur_i  (stage[g]),
      .nxt_o  (stage[g+1])
    );
  end

  assign nxt_o    = stage[NUM_CORES];
  assign any_we_o = |we_i;

  AST_CHAIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_we_o |-> (nxt_o == cur_i)); // R9

endmodule

// File: rtl/gpio_oe_store.sv
module gpio_oe_store #(
  parameter int unsigned NUM_PINS = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [NUM_PINS-1:0] d_i,
  output logic [NUM_PINS-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R9
  AST_OUT_OF_RESET: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (q_o == '0)); // R1

endmodule

// File: rtl/gpio_oe_dual_core.sv
module gpio_oe_dual_core
  import gpio_oe_pkg::*;
#(
  parameter int unsigned NUM_PINS = 30,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              c0_we_i,
  input  logic [1:0]        c0_op_i,
  input  logic [DATA_W-1:0] c0_wdata_i,
  output logic [DATA_W-1:0] c0_rdata_o,
  input  logic              c1_we_i,
  input  logic [1:0]        c1_op_i,
  input  logic [DATA_W-1:0] c1_wdata_i,
  output logic [DATA_W-1:0] c1_rdata_o,
  output logic [NUM_PINS-1:0] oe_o
);

  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned PAD_W     = DATA_W - NUM_PINS;

  logic [NUM_CORES-1:0] we;
  oe_op_e               op   [NUM_CORES];
  logic [NUM_PINS-1:0]  data [NUM_CORES];
  logic [NUM_PINS-1:0]  nxt;
  logic [NUM_PINS-1:0]  cur;
  logic                 any_we;
  logic                 unused_hi;

  assign we      = {c1_we_i, c0_we_i};
  assign op[0]   = oe_op_e'(c0_op_i);
  assign op[1]   = oe_op_e'(c1_op_i);
  // bits above the pin count have no storage
  assign data[0] = c0_wdata_i[NUM_PINS-1:0];
  assign data[1] = c1_wdata_i[NUM_PINS-1:0];
  assign unused_hi = ^{c0_wdata_i[DATA_W-1:NUM_PINS], c1_wdata_i[DATA_W-1:NUM_PINS]};

  gpio_oe_merge_chain #(
    .NUM_PINS (NUM_PINS),
    .NUM_CORES(NUM_CORES)
  ) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .op_i     (op),
    .data_i   (data),
    .cur_i    (cur),
    .nxt_o    (nxt),
    .any_we_o (any_we)
  );

  gpio_oe_store #(
    .NUM_PINS(NUM_PINS)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (any_we),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign oe_o       = cur;
  assign c0_rdata_o = {{PAD_W{1'b0}}, cur};
  assign c1_rdata_o = {{PAD_W{1'b0}}, cur};

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0_rdata_o[DATA_W-1:NUM_PINS] == '0) && (c1_rdata_o[DATA_W-1:NUM_PINS] == '0)); // R3
  AST_READ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0_rdata_o[NUM_PINS-1:0] == oe_o) && (c1_rdata_o == c0_rdata_o)); // R10
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!c0_we_i && !c1_we_i) |=> $stable(oe_o)); // R9

endmodule

// File: tb/gpio_oe_dual_core_tb.sv
`timescale 1ns/1ps
module gpio_oe_dual_core_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        c0_we = 1'b0, c1_we = 1'b0;
  logic [1:0]  c0_op = '0, c1_op = '0;
  logic [31:0] c0_wd = '0, c1_wd = '0;
  logic [31:0] c0_rd, c1_rd;
  logic [29:0] oe;

  int n_vec = 0;
  int n_bad = 0;
  logic [29:0] model = '0;

  always #4 clk = ~clk;

  gpio_oe_dual_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .c0_we_i(c0_we), .c0_op_i(c0_op), .c0_wdata_i(c0_wd), .c0_rdata_o(c0_rd),
    .c1_we_i(c1_we), .c1_op_i(c1_op), .c1_wdata_i(c1_wd), .c1_rdata_o(c1_rd),
    .oe_o(oe)
  );

  function automatic logic [29:0] f_apply(logic [29:0] cur, logic [1:0] op, logic [31:0] d);
    logic [29:0] m;
    m = d[29:0];
    case (op)
      2'b00:   return m;
      2'b01:   return cur | m;
      2'b10:   return cur & ~m;
      default: return cur ^ m;
    endcase
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (oe !== model || c0_rd !== {2'b00, model} || c1_rd !== {2'b00, model}) begin
      n_bad++;
      $display("FAIL %s: oe=%h rd0=%h rd1=%h expected oe=%h rd=%h",
               tag, oe, c0_rd, c1_rd, model, {2'b00, model});
    end
  endtask

  task automatic step(logic w0, logic [1:0] o0, logic [31:0] d0,
                      logic w1, logic [1:0] o1, logic [31:0] d1, string tag);
    @(negedge clk);
    c0_we = w0; c0_op = o0; c0_wd = d0;
    c1_we = w1; c1_op = o1; c1_wd = d1;
    if (w0) model = f_apply(model, o0, d0);
    if (w1) model = f_apply(model, o1, d1);
    @(negedge clk);
    c0_we = 1'b0; c1_we = 1'b0;
    check(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0E0E));
    repeat (3) @(negedge clk);
    check("R1 reset value");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step(1, 2'b00, 32'h1234_5678, 0, 2'b00, 0, "R2 plain core0");
    step(0, 2'b00, 0, 1, 2'b00, 32'h0ABC_DEF0, "R2 R7 plain core1");
    step(1, 2'b00, 32'hC000_0000, 0, 2'b00, 0, "R3 upper bits plain");
    step(1, 2'b01, 32'hFFFF_0000, 0, 2'b00, 0, "R4 set core0");
    step(1, 2'b01, 32'hC000_0000, 0, 2'b00, 0, "R3 upper bits set");
    step(0, 2'b00, 0, 1, 2'b10, 32'h0F0F_0000, "R5 clear core1");
    step(0, 2'b00, 0, 1, 2'b11, 32'hC000_00FF, "R6 R3 toggle core1");
    step(0, 2'b00, 0, 0, 2'b00, 0, "R9 idle hold");
    step(0, 2'b11, 32'h3FFF_FFFF, 0, 2'b01, 32'h3FFF_FFFF, "R9 idle ops ignored");
    step(1, 2'b00, 32'h0000_0001, 1, 2'b11, 32'h0000_0001, "R8 plain then toggle");
    step(1, 2'b10, 32'hFFFF_FFFF, 1, 2'b01, 32'h0000_0005, "R8 clear then set");
    step(1, 2'b01, 32'h0000_000F, 1, 2'b10, 32'h0000_0003, "R8 set then clear");
    step(1, 2'b11, 32'h0000_00F0, 1, 2'b00, 32'h1555_5555, "R8 toggle then plain");
    step(1, 2'b01, 32'h3FFF_FFFF, 0, 2'b00, 0, "R4 all pins output");

    @(negedge clk);
    rst_ni = 1'b0;
    model = '0;
    #1;
    check("R1 async reset midrun");
    @(negedge clk);
    check("R1 reset held");
    rst_ni = 1'b1;

    for (int i = 0; i < 3000; i++) begin
      logic w0, w1;
      logic [1:0] o0, o1;
      w0 = 1'($urandom);
      w1 = 1'($urandom);
      o0 = 2'($urandom);
      o1 = 2'($urandom);
      step(w0, o0, $urandom, w1, o1, $urandom,
           (w0 && w1) ? "R8 random pair" : ((w0 || w1) ? "R7 random single" : "R9 random idle"));
    end
    check("R10 final readback");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule